// File: doc/BRIEF.md
# Two-Level Burst/Transfer DMA Channel

This block is a single DMA channel that copies 16-bit words from a source address to a destination address, usually between a peripheral data register pair and a buffer in memory. Each selected peripheral event moves one burst of words. Bursts are grouped into a transfer. The source and destination pointers each have their own signed step inside a burst and their own signed step between bursts. Each pointer also has an optional wrap limit that sends it back to its start address.

Software programs the channel through a small register port. The two start addresses are written into shadow registers. These are copied into the active pointers when the channel is started, so software can prepare the next buffer while the current transfer is still running. At the end of a transfer the channel can pulse an interrupt. In continuous mode it reloads the pointers from the shadows and arms itself again with no software action.

Each word takes two cycles. In the first cycle the channel reads the source; the memory returns the data one cycle later. In the second cycle the channel writes that data to the destination.

Top module: `bxdma_chan`

## Requirements
- R1: Register offset 2 holds the burst size minus one. Each accepted trigger moves exactly that value plus one words. A word is a read strobe at the source address followed in the next cycle by a write strobe at the destination address, carrying the data that memory returned one cycle after the read.
- R2: Register offset 3 holds the transfer size minus one. The transfer ends after that value plus one bursts. Status bit 0 (running, read at offset 0) stays 1 until then.
- R3: After every word except the last of a burst, each pointer adds its own signed burst step. The source step is at offset 4 and the destination step at offset 5, both 16-bit two's complement.
- R4: After the last word of a burst, each pointer adds its own signed transfer step instead (source at offset 6, destination at offset 7). A value of 0xFFFF steps back by one word.
- R5: Wrap limits sit at offset 8 (source) and offset 9 (destination). Each counts down once per burst. When a pointer's counter is zero at a burst end, the pointer returns to its start address and the counter reloads. A limit of all ones turns wrapping off for that pointer.
- R6: The start addresses are written to shadow registers at offset 10 (source) and offset 11 (destination). They are copied into the active pointers only when the channel is started or re-armed. A shadow write during a transfer does not change the addresses that transfer uses.
- R7: The mode register is at offset 1. Bits 3:0 select which trigger input starts bursts, and bit 4 enables triggers. Triggers on other inputs, or with bit 4 clear, move nothing.
- R8: The interrupt output pulses for exactly one cycle after the last write of a transfer, and only when mode bit 5 (end-of-transfer interrupt) and mode bit 7 (interrupt enable) are both set.
- R9: When mode bit 6 (continuous) is set, the end of a transfer reloads both pointers from the shadows and restarts the burst count. The running bit stays 1.
- R10: A trigger that arrives during a burst is held as pending (status bit 1) and starts the next burst once the current one finishes. A further trigger while one is already pending sets the overflow flag (status bit 2). Writing bit 2 of offset 0 clears the pending trigger, and writing bit 3 of offset 0 clears the overflow flag.
- R11: Without continuous mode, the running bit clears at the end of a transfer. Triggers then move nothing until bit 0 of offset 0 (run) is written again.
- R12: After reset, and after a write of bit 1 of offset 0 (halt), the channel is stopped: the status reads 0 and no memory access occurs on a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| trig | input | NTRIG | Peripheral event inputs, one event per cycle high |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| irq | output | 1 | End-of-transfer interrupt pulse |

## Verification
The bench builds the channel with a 10-bit address, 6-bit counters and four trigger inputs. With these values the memory model is small enough to compare in full after every transfer. Negative steps wrap modulo the address space, and the all-ones wrap limit is the 6-bit value 63. Using four trigger inputs makes it possible to drive a trigger on a wrong select line and check that it is ignored.

// File: rtl/bxdma_pkg.sv
package bxdma_pkg;

    localparam int RDW = 16;

    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_MODE   = 4'd1;
    localparam logic [3:0] RA_BSIZE  = 4'd2;
    localparam logic [3:0] RA_TSIZE  = 4'd3;
    localparam logic [3:0] RA_SBSTEP = 4'd4;
    localparam logic [3:0] RA_DBSTEP = 4'd5;
    localparam logic [3:0] RA_STSTEP = 4'd6;
    localparam logic [3:0] RA_DTSTEP = 4'd7;
    localparam logic [3:0] RA_SWRAP  = 4'd8;
    localparam logic [3:0] RA_DWRAP  = 4'd9;
    localparam logic [3:0] RA_SADDR  = 4'd10;
    localparam logic [3:0] RA_DADDR  = 4'd11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } eng_st_t;

    typedef struct packed {
        logic clr_err;
        logic clr_pend;
        logic halt;
        logic run;
    } cmd_t;

    typedef struct packed {
        logic       int_en;
        logic       cont;
        logic       eot_int;
        logic       evt_en;
        logic [3:0] sel;
    } mode_t;

    typedef struct packed {
        logic [RDW-1:0] bstep;
        logic [RDW-1:0] tstep;
        logic [RDW-1:0] wsize;
        logic [RDW-1:0] addr;
    } ptr_cfg_t;

    function automatic logic [RDW-1:0] zext3(input logic [2:0] v);
        return {{(RDW-3){1'b0}}, v};
    endfunction

endpackage

// File: rtl/bxdma_regs.sv
module bxdma_regs
    import bxdma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [3:0]     reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    input  logic [2:0]     status,
    output cmd_t           cmd,
    output mode_t          mode,
    output logic [CW-1:0]  bsize,
    output logic [CW-1:0]  tsize,
    output ptr_cfg_t       src_cfg,
    output ptr_cfg_t       dst_cfg
);

    always_comb begin
        cmd = '0;
        if (reg_wr && reg_addr == RA_CTRL) cmd = cmd_t'(reg_wdata[3:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            bsize   <= '0;
            tsize   <= '0;
            src_cfg <= '{bstep: '0, tstep: '0, wsize: '1, addr: '0};
            dst_cfg <= '{bstep: '0, tstep: '0, wsize: '1, addr: '0};
        end else if (reg_wr) begin
            case (reg_addr)
                RA_MODE:   mode          <= mode_t'(reg_wdata[7:0]);
                RA_BSIZE:  bsize         <= reg_wdata[CW-1:0];
                RA_TSIZE:  tsize         <= reg_wdata[CW-1:0];
                RA_SBSTEP: src_cfg.bstep <= reg_wdata;
                RA_DBSTEP: dst_cfg.bstep <= reg_wdata;
                RA_STSTEP: src_cfg.tstep <= reg_wdata;
                RA_DTSTEP: dst_cfg.tstep <= reg_wdata;
                RA_SWRAP:  src_cfg.wsize <= reg_wdata;
                RA_DWRAP:  dst_cfg.wsize <= reg_wdata;
                RA_SADDR:  src_cfg.addr  <= reg_wdata;
                RA_DADDR:  dst_cfg.addr  <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = zext3(status);
            RA_MODE:   reg_rdata = {{(RDW-8){1'b0}}, mode};
            RA_BSIZE:  reg_rdata = RDW'(bsize);
            RA_TSIZE:  reg_rdata = RDW'(tsize);
            RA_SBSTEP: reg_rdata = src_cfg.bstep;
            RA_DBSTEP: reg_rdata = dst_cfg.bstep;
            RA_STSTEP: reg_rdata = src_cfg.tstep;
            RA_DTSTEP: reg_rdata = dst_cfg.tstep;
            RA_SWRAP:  reg_rdata = src_cfg.wsize;
            RA_DWRAP:  reg_rdata = dst_cfg.wsize;
            RA_SADDR:  reg_rdata = src_cfg.addr;
            RA_DADDR:  reg_rdata = dst_cfg.addr;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bxdma_ptr.sv
module bxdma_ptr
    import bxdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  ptr_cfg_t      cfg,
    input  logic          word_adv,
    input  logic          burst_adv,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] beg_q;
    logic [CW-1:0] wcnt_q;
    logic          wrap_on;

    assign wrap_on = ~&cfg.wsize[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            beg_q  <= '0;
            wcnt_q <= '0;
        end else if (load) begin
            addr   <= cfg.addr[AW-1:0];
            beg_q  <= cfg.addr[AW-1:0];
            wcnt_q <= cfg.wsize[CW-1:0];
        end else if (burst_adv) begin
            if (wrap_on && wcnt_q == '0) begin
                addr   <= beg_q;
                wcnt_q <= cfg.wsize[CW-1:0];
            end else begin
                addr <= addr + cfg.tstep[AW-1:0];
                if (wrap_on) wcnt_q <= wcnt_q - CW'(1);
            end
        end else if (word_adv) begin
            addr <= addr + cfg.bstep[AW-1:0];
        end
    end

endmodule

// File: rtl/bxdma_ctrl.sv
module bxdma_ctrl
    import bxdma_pkg::*;
#(
    parameter int CW    = 16,
    parameter int NTRIG = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  mode_t            mode,
    input  logic [CW-1:0]    bsize,
    input  logic [CW-1:0]    tsize,
    input  logic [NTRIG-1:0] trig,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             load,
    output logic             word_adv,
    output logic             burst_adv,
    output logic             irq,
    output logic [2:0]       status
);

    eng_st_t       st_q;
    logic [CW-1:0] wcnt_q;
    logic [CW-1:0] bcnt_q;
    logic          running_q;
    logic          pend_q;
    logic          ovf_q;
    logic [15:0]   trig_w;
    logic          evt;
    logic          start;
    logic          last_word;
    logic          last_burst;

    assign trig_w     = 16'(trig);
    assign evt        = running_q & mode.evt_en & trig_w[mode.sel];
    assign start      = (st_q == ST_IDLE) & running_q & (evt | pend_q);
    assign last_word  = (st_q == ST_WR) & (wcnt_q == '0);
    assign last_burst = last_word & (bcnt_q == '0);

    assign mem_rd    = (st_q == ST_RD);
    assign mem_wr    = (st_q == ST_WR);
    assign word_adv  = (st_q == ST_WR) & (wcnt_q != '0);
    assign burst_adv = last_word;
    assign load      = (cmd.run & ~cmd.halt) | (last_burst & mode.cont);
    assign status    = {ovf_q, pend_q, running_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            wcnt_q    <= '0;
            bcnt_q    <= '0;
            running_q <= 1'b0;
            pend_q    <= 1'b0;
            ovf_q     <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= last_burst & mode.eot_int & mode.int_en;

            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_RD;
                        wcnt_q <= bsize;
                        pend_q <= pend_q & evt;
                    end
                end
                ST_RD: st_q <= ST_WR;
                ST_WR: begin
                    if (wcnt_q == '0) begin
                        st_q <= ST_IDLE;
                        if (bcnt_q != '0) bcnt_q <= bcnt_q - CW'(1);
                    end else begin
                        wcnt_q <= wcnt_q - CW'(1);
                        st_q   <= ST_RD;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase

            if (st_q != ST_IDLE && evt) begin
                if (pend_q) ovf_q  <= 1'b1;
                else        pend_q <= 1'b1;
            end

            if (last_burst) begin
                bcnt_q <= tsize;
                if (!mode.cont) begin
                    running_q <= 1'b0;
                    pend_q    <= 1'b0;
                end
            end

            if (cmd.clr_pend) pend_q <= 1'b0;
            if (cmd.clr_err)  ovf_q  <= 1'b0;

            if (cmd.run) begin
                running_q <= 1'b1;
                bcnt_q    <= tsize;
                st_q      <= ST_IDLE;
                pend_q    <= 1'b0;
            end
            if (cmd.halt) begin
                running_q <= 1'b0;
                st_q      <= ST_IDLE;
                pend_q    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bxdma_chan.sv
module bxdma_chan
    import bxdma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int NTRIG = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [NTRIG-1:0] trig,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    output logic             irq
);

    localparam int NPTR = 2;

    cmd_t          cmd;
    mode_t         mode;
    logic [CW-1:0] bsize;
    logic [CW-1:0] tsize;
    ptr_cfg_t      cfgs [NPTR];
    logic [AW-1:0] addrs [NPTR];
    logic [2:0]    stat;
    logic          load;
    logic          word_adv;
    logic          burst_adv;

    bxdma_regs #(.CW(CW)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status    (stat),
        .cmd       (cmd),
        .mode      (mode),
        .bsize     (bsize),
        .tsize     (tsize),
        .src_cfg   (cfgs[0]),
        .dst_cfg   (cfgs[1])
    );

    bxdma_ctrl #(.CW(CW), .NTRIG(NTRIG)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .mode      (mode),
        .bsize     (bsize),
        .tsize     (tsize),
        .trig      (trig),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .load      (load),
        .word_adv  (word_adv),
        .burst_adv (burst_adv),
        .irq       (irq),
        .status    (stat)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        bxdma_ptr #(.AW(AW), .CW(CW)) i_ptr (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .cfg       (cfgs[g]),
            .word_adv  (word_adv),
            .burst_adv (burst_adv),
            .addr      (addrs[g])
        );
    end

    assign mem_addr  = mem_wr ? addrs[1] : addrs[0];
    assign mem_wdata = mem_rdata;

endmodule

// File: rtl/bxdma_chan_chk.sv
module bxdma_chan_chk (
    input logic clk,
    input logic rst,
    input logic mem_rd,
    input logic mem_wr,
    input logic irq,
    input logic running,
    input logic ovf,
    input logic clr_err
);

    // R1: a write always follows a read of the same word
    a_r1_write_after_read: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));

    // R12: a stopped channel issues no read in the next cycle
    a_r12_no_read_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !running |=> !mem_rd);

    // R8: the interrupt is a single-cycle pulse
    a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8: the interrupt follows the final write of a transfer
    a_r8_irq_after_write: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_wr));

    // R10: the overflow flag holds until software clears it
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_err) |=> ovf);

    // R12: reset leaves the memory port and interrupt quiet
    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> (!mem_rd && !mem_wr && !irq));

endmodule

bind bxdma_chan bxdma_chan_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .irq     (irq),
    .running (stat[0]),
    .ovf     (stat[2]),
    .clr_err (cmd.clr_err)
);

// File: tb/test_bxdma_chan.sv
module test_bxdma_chan;

    localparam int AW    = 10;
    localparam int CW    = 6;
    localparam int NTRIG = 4;
    localparam int MEMN  = 1 << AW;
    localparam int MASK  = MEMN - 1;
    localparam int CM    = (1 << CW) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic [NTRIG-1:0] trig = '0;
    logic             mem_rd;
    logic             mem_wr;
    logic [AW-1:0]    mem_addr;
    logic [15:0]      mem_wdata;
    logic [15:0]      mem_rdata = '0;
    logic             irq;

    logic [15:0] mem     [MEMN];
    logic [15:0] ref_mem [MEMN];
    int irq_cnt = 0;
    int acc_cnt = 0;
    int nchk = 0;
    int nbad = 0;

    // configuration and model state
    int c_bsz, c_tsz, c_src, c_dst, c_swr, c_dwr, c_sel;
    logic [15:0] c_sbs, c_dbs, c_sts, c_dts;
    logic [7:0]  c_mode;
    int m_s, m_d, m_sb, m_db, m_swc, m_dwc, m_bl;

    always #2.5 clk = ~clk;

    bxdma_chan #(.AW(AW), .CW(CW), .NTRIG(NTRIG)) i_bxdma_chan (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (rst) begin
            irq_cnt <= 0;
            acc_cnt <= 0;
        end else begin
            if (irq) irq_cnt <= irq_cnt + 1;
            if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire_n(input int s, input int n);
        @(negedge clk);
        trig[s] = 1'b1;
        repeat (n) @(negedge clk);
        trig = '0;
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < MEMN; i++) if (mem[i] !== ref_mem[i]) d++;
        return d;
    endfunction

    task automatic model_load();
        m_s = c_src & MASK; m_d = c_dst & MASK;
        m_sb = m_s; m_db = m_d;
        m_swc = c_swr & CM; m_dwc = c_dwr & CM;
        m_bl = c_tsz;
    endtask

    task automatic model_burst();
        for (int w = 0; w <= c_bsz; w++) begin
            ref_mem[m_d] = ref_mem[m_s];
            if (w < c_bsz) begin
                m_s = (m_s + int'(c_sbs)) & MASK;
                m_d = (m_d + int'(c_dbs)) & MASK;
            end else begin
                if ((c_swr & CM) != CM && m_swc == 0) begin
                    m_s = m_sb; m_swc = c_swr & CM;
                end else begin
                    m_s = (m_s + int'(c_sts)) & MASK;
                    if ((c_swr & CM) != CM) m_swc--;
                end
                if ((c_dwr & CM) != CM && m_dwc == 0) begin
                    m_d = m_db; m_dwc = c_dwr & CM;
                end else begin
                    m_d = (m_d + int'(c_dts)) & MASK;
                    if ((c_dwr & CM) != CM) m_dwc--;
                end
            end
        end
        if (m_bl == 0) begin
            if (c_mode[6]) model_load();
        end else begin
            m_bl--;
        end
    endtask

    task automatic program_cfg();
        wr_reg(4'd1, {8'h0, c_mode});
        wr_reg(4'd2, 16'(c_bsz));
        wr_reg(4'd3, 16'(c_tsz));
        wr_reg(4'd4, c_sbs);
        wr_reg(4'd5, c_dbs);
        wr_reg(4'd6, c_sts);
        wr_reg(4'd7, c_dts);
        wr_reg(4'd8, 16'(c_swr));
        wr_reg(4'd9, 16'(c_dwr));
        wr_reg(4'd10, 16'(c_src));
        wr_reg(4'd11, 16'(c_dst));
    endtask

    task automatic start_run();
        wr_reg(4'd0, 16'h0001);
        model_load();
    endtask

    task automatic bursts(input int n);
        for (int b = 0; b < n; b++) begin
            fire_n(c_sel, 1);
            wait_cyc(2 * (c_bsz + 1) + 3);
            model_burst();
        end
    endtask

    task automatic basic_cfg(input int sel);
        c_sel = sel;
        c_mode = 8'hB0 | 8'(sel);
        c_bsz = 1; c_tsz = 2;
        c_sbs = 16'd1; c_dbs = 16'd1; c_sts = 16'd1; c_dts = 16'd1;
        c_swr = 16'hFFFF; c_dwr = 16'hFFFF;
        c_src = 16; c_dst = 600;
    endtask

    logic [15:0] rv;
    int a0, i0;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < MEMN; i++) begin
            mem[i] = 16'($urandom);
            ref_mem[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wait_cyc(3);

        // R12: reset state
        rd_reg(4'd0, rv);
        check(rv == 16'h0, "R12 reset status", int'(rv), 0);
        check(acc_cnt == 0 && irq_cnt == 0, "R12 reset quiet", acc_cnt + irq_cnt, 0);
        fire_n(0, 2);
        wait_cyc(4);
        check(acc_cnt == 0, "R12 trigger before run", acc_cnt, 0);

        // R1 R3 R4: peripheral pair source (+1 then -1), linear destination
        basic_cfg(2);
        c_tsz = 4; c_sts = 16'hFFFF; c_src = 100; c_dst = 200;
        program_cfg();
        start_run();
        i0 = irq_cnt;
        bursts(4);
        rd_reg(4'd0, rv);
        check(rv[0] == 1'b1, "R2 running before last burst", int'(rv[0]), 1);
        check(irq_cnt == i0, "R8 no early irq", irq_cnt - i0, 0);
        bursts(1);
        check(mem_diff() == 0, "R1 R3 R4 pair copy", mem_diff(), 0);
        check(mem[204] == mem[100] && mem[205] == mem[101], "R4 step back", int'(mem[205]), int'(mem[101]));
        rd_reg(4'd0, rv);
        check(rv[0] == 1'b0, "R2 running clears at end", int'(rv[0]), 0);
        check(irq_cnt == i0 + 1, "R8 one irq per transfer", irq_cnt - i0, 1);

        // R11: trigger after end is ignored
        a0 = acc_cnt;
        fire_n(2, 1);
        wait_cyc(8);
        check(acc_cnt == a0, "R11 ignored after end", acc_cnt - a0, 0);
        check(mem_diff() == 0, "R11 memory untouched", mem_diff(), 0);

        // R7: wrong select and disabled event
        basic_cfg(1);
        program_cfg();
        start_run();
        a0 = acc_cnt;
        fire_n(3, 1);
        wait_cyc(8);
        check(acc_cnt == a0, "R7 other trigger ignored", acc_cnt - a0, 0);
        wr_reg(4'd1, 16'(c_mode & 8'hEF));
        fire_n(1, 1);
        wait_cyc(8);
        check(acc_cnt == a0, "R7 event disable", acc_cnt - a0, 0);
        wr_reg(4'd1, 16'(c_mode));
        bursts(1);
        check(acc_cnt - a0 == 4, "R1 two words per burst", acc_cnt - a0, 4);
        bursts(2);
        check(mem_diff() == 0, "R7 selected trigger copy", mem_diff(), 0);

        // R8: interrupt gating
        basic_cfg(0);
        c_mode = 8'h30; c_src = 40; c_dst = 700;
        program_cfg();
        start_run();
        i0 = irq_cnt;
        bursts(3);
        check(irq_cnt == i0, "R8 no irq without enable", irq_cnt - i0, 0);
        c_mode = 8'h90;
        program_cfg();
        start_run();
        bursts(3);
        check(irq_cnt == i0, "R8 no irq without end mode", irq_cnt - i0, 0);
        check(mem_diff() == 0, "R8 copies", mem_diff(), 0);

        // R5: destination wrap every two bursts, source linear
        basic_cfg(3);
        c_bsz = 2; c_tsz = 5; c_dwr = 1; c_src = 300; c_dst = 800;
        c_dts = 16'd3;
        program_cfg();
        start_run();
        bursts(6);
        check(mem_diff() == 0, "R5 wrap", mem_diff(), 0);
        check(mem[800] == mem[312], "R5 returns to start", int'(mem[800]), int'(mem[312]));

        // R6: shadow write mid-transfer has no effect on this transfer
        basic_cfg(0);
        c_tsz = 3; c_src = 500; c_dst = 900;
        program_cfg();
        start_run();
        bursts(1);
        wr_reg(4'd10, 16'd20);
        wr_reg(4'd11, 16'd950);
        bursts(3);
        check(mem_diff() == 0, "R6 active pointers kept", mem_diff(), 0);
        c_src = 20; c_dst = 950;
        start_run();
        bursts(4);
        check(mem_diff() == 0, "R6 new shadows on run", mem_diff(), 0);

        // R9: continuous re-arm, then R12 halt
        basic_cfg(1);
        c_mode = 8'hF1; c_tsz = 1; c_src = 60; c_dst = 400;
        c_sbs = 16'hFFFE; c_sts = 16'd5;
        program_cfg();
        start_run();
        i0 = irq_cnt;
        bursts(4);
        rd_reg(4'd0, rv);
        check(rv[0] == 1'b1, "R9 still running", int'(rv[0]), 1);
        check(irq_cnt == i0 + 2, "R9 irq each transfer", irq_cnt - i0, 2);
        check(mem_diff() == 0, "R9 reload copy", mem_diff(), 0);
        wr_reg(4'd0, 16'h0002);
        rd_reg(4'd0, rv);
        check(rv == 16'h0, "R12 halt status", int'(rv), 0);
        a0 = acc_cnt;
        fire_n(1, 1);
        wait_cyc(8);
        check(acc_cnt == a0, "R12 halted ignores trigger", acc_cnt - a0, 0);

        // R10: pending and overflow
        basic_cfg(2);
        c_bsz = 3; c_tsz = 3; c_src = 120; c_dst = 140;
        program_cfg();
        start_run();
        fire_n(2, 3);
        rd_reg(4'd0, rv);
        check(rv[2:1] == 2'b11, "R10 pending and overflow", int'(rv[2:1]), 3);
        wait_cyc(20);
        model_burst();
        model_burst();
        rd_reg(4'd0, rv);
        check(rv[2:0] == 3'b101, "R10 pending consumed", int'(rv[2:0]), 5);
        wr_reg(4'd0, 16'h0008);
        rd_reg(4'd0, rv);
        check(rv[2] == 1'b0, "R10 clear overflow", int'(rv[2]), 0);
        fire_n(2, 2);
        wr_reg(4'd0, 16'h0004);
        rd_reg(4'd0, rv);
        check(rv[1] == 1'b0, "R10 clear pending", int'(rv[1]), 0);
        wait_cyc(12);
        model_burst();
        check(mem_diff() == 0, "R10 one burst after clear", mem_diff(), 0);
        bursts(1);
        rd_reg(4'd0, rv);
        check(rv[0] == 1'b0, "R2 end after four bursts", int'(rv[0]), 0);
        check(mem_diff() == 0, "R10 final copy", mem_diff(), 0);

        // R1..R5: constrained random transfers
        for (int it = 0; it < 8; it++) begin
            c_sel = $urandom_range(0, NTRIG - 1);
            c_mode = 8'hB0 | 8'(c_sel);
            c_bsz = $urandom_range(0, 3);
            c_tsz = $urandom_range(0, 5);
            c_sbs = 16'($urandom_range(0, 8) - 4);
            c_dbs = 16'($urandom_range(0, 8) - 4);
            c_sts = 16'($urandom_range(0, 8) - 4);
            c_dts = 16'($urandom_range(0, 8) - 4);
            c_swr = ($urandom_range(0, 1) != 0) ? 16'hFFFF : $urandom_range(0, 3);
            c_dwr = ($urandom_range(0, 1) != 0) ? 16'hFFFF : $urandom_range(0, 3);
            c_src = $urandom_range(0, MEMN - 1);
            c_dst = $urandom_range(0, MEMN - 1);
            program_cfg();
            start_run();
            i0 = irq_cnt;
            bursts(c_tsz + 1);
            check(mem_diff() == 0, "R3 R4 R5 random copy", mem_diff(), 0);
            check(irq_cnt == i0 + 1, "R8 random irq", irq_cnt - i0, 1);
            rd_reg(4'd0, rv);
            check(rv[0] == 1'b0, "R2 random end", int'(rv[0]), 0);
        end

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule